// File: doc/BRIEF.md
# GPIO Group Interrupt Detector

The block watches several groups of eight general-purpose input pins and turns pin activity into interrupt requests. Each pin has its own 3-bit trigger code that selects one of five detection rules: the pin being low, the pin being high, a high-to-low transition, a low-to-high transition, or any transition. A detected event sets a per-pin pending flag, and a per-pin disable flag keeps that pending flag from reaching the output. One combined request line is raised while any pin in any group is both pending and enabled.

Software programs trigger codes, reads and writes the disable flags, and acknowledges pending flags over a plain single-cycle register bus with a combinational read path. Pending flags are cleared by writing ones. The pin inputs must already be synchronised to the block clock. Edge rules compare each pin with its value from the previous clock; level rules re-raise the pending flag on every clock the level holds, so an acknowledged level interrupt returns at once while the pin stays at its level.

Top module: `gpint_ctrl`

## Requirements
- R1: After reset every disable bit reads 1, every trigger code reads 0, every pending bit reads 0 (pins held high through reset), and `irq_o` is 0.
- R2: Register map: trigger words at 0x700 + 4*g, disable words at 0x900 + 4*g, pending words at 0xA00 + 4*g for group g; pin n's trigger code lives in bits [4n+2:4n] and bit 4n+3 reads 0; disable and pending words use bits [7:0] only and read 0 above.
- R3: Code 0 sets the pending bit on every clock the pin is low, so it re-asserts after a clear while the pin stays low.
- R4: Code 1 sets the pending bit on every clock the pin is high; once the pin is low a clear sticks.
- R5: Code 2 sets the pending bit one clock after a 1-to-0 change only; a 0-to-1 change or a steady low does not set it.
- R6: Code 3 sets the pending bit one clock after a 0-to-1 change only.
- R7: Code 4 sets the pending bit one clock after a change in either direction.
- R8: Codes 5, 6 and 7 never set the pending bit.
- R9: Writing 1 to a pending bit clears it; writing 0 leaves it unchanged.
- R10: When a new event and a clearing write hit the same pending bit in the same clock, the bit ends set.
- R11: `irq_o` is 1 exactly when some pending bit has its disable bit at 0; a disabled pin still records pending.
- R12: Reads of addresses outside the three banks (including unaligned ones) return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 32 | Synchronised pin levels, group g pin n at bit 8g+n |
| bus_we_i | input | 1 | Write strobe, one write per clock |
| bus_addr_i | input | 12 | Byte address for read and write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A pin change or a register write takes effect at the first rising clock edge after it is driven: pending flags and `irq_o` follow a pin change after exactly one edge, and a read reflects a write one edge later since the read port itself adds no delay. The bench drives every stimulus just after a falling edge and queues the expected value; the monitor pops it at the next falling edge, so each check sees precisely one rising edge after its stimulus. Level-mode sequences are planned so that the flag state at that single edge is known, and the event-versus-clear collision is driven in one cycle on purpose.

// File: rtl/gpint_pkg.sv
package gpint_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned SLOT_W = 4;

  typedef enum logic [CODE_W-1:0] {
    TRIG_LOW  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_RISE = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;
endpackage

// File: rtl/gpint_detect.sv
module gpint_detect
  import gpint_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  always_comb begin
    case (code_i)
      TRIG_LOW:  evt_o = ~pin_i;
      TRIG_HIGH: evt_o = pin_i;
      TRIG_FALL: evt_o = prev_q & ~pin_i;
      TRIG_RISE: evt_o = ~prev_q & pin_i;
      TRIG_BOTH: evt_o = prev_q ^ pin_i;
      default:   evt_o = 1'b0;
    endcase
  end

  // R8: reserved codes stay silent
  a_r8_reserved_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i > 3'd4) |-> !evt_o);
endmodule

// File: rtl/gpint_group.sv
module gpint_group
  import gpint_pkg::*;
#(
  parameter int unsigned PINS   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PINS-1:0]   pins_i,
  input  logic              ctrl_we_i,
  input  logic              mask_we_i,
  input  logic              pend_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [PINS-1:0]   mask_o,
  output logic [PINS-1:0]   pend_o
);
  logic [CODE_W-1:0] code_q [PINS];
  logic [PINS-1:0]   evt;
  logic [PINS-1:0]   clr;
  logic [PINS-1:0]   mask_q, pend_q;

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        code_q[n] <= '0;
      else if (ctrl_we_i) code_q[n] <= wdata_i[SLOT_W*n +: CODE_W];
    end

    gpint_detect u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins_i[n]),
      .code_i (code_q[n]),
      .evt_o  (evt[n])
    );
  end

  always_comb begin
    ctrl_o = '0;
    for (int n = 0; n < PINS; n++) ctrl_o[SLOT_W*n +: CODE_W] = code_q[n];
  end

  assign clr = pend_we_i ? wdata_i[PINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i[PINS-1:0];
      pend_q <= (pend_q & ~clr) | evt;  // event beats clear
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

  a_r9_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr & ~evt) != '0) |=> ((pend_q & $past(clr & ~evt)) == '0));

  a_r10_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/gpint_ctrl.sv
module gpint_ctrl
  import gpint_pkg::*;
#(
  parameter int unsigned NGROUP = 4,
  parameter int unsigned PINS   = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 12'h700,
  parameter logic [ADDR_W-1:0] MASK_BASE = 12'h900,
  parameter logic [ADDR_W-1:0] PEND_BASE = 12'hA00
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NGROUP*PINS-1:0] pins_i,
  input  logic                   bus_we_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [DATA_W-1:0]      bus_wdata_i,
  output logic [DATA_W-1:0]      bus_rdata_o,
  output logic                   irq_o
);
  localparam int unsigned STRIDE = 4;
  localparam int unsigned NPINS  = NGROUP * PINS;

  logic [NGROUP-1:0] sel_c, sel_m, sel_p;
  logic [DATA_W-1:0] ctrl_w [NGROUP];
  logic [PINS-1:0]   mask_w [NGROUP];
  logic [PINS-1:0]   pend_w [NGROUP];
  logic [NPINS-1:0]  mask_flat, pend_flat;

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    assign sel_c[g] = (bus_addr_i == ADDR_W'(CTRL_BASE + STRIDE*g));
    assign sel_m[g] = (bus_addr_i == ADDR_W'(MASK_BASE + STRIDE*g));
    assign sel_p[g] = (bus_addr_i == ADDR_W'(PEND_BASE + STRIDE*g));

    gpint_group #(.PINS(PINS), .DATA_W(DATA_W)) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pins_i    (pins_i[g*PINS +: PINS]),
      .ctrl_we_i (bus_we_i & sel_c[g]),
      .mask_we_i (bus_we_i & sel_m[g]),
      .pend_we_i (bus_we_i & sel_p[g]),
      .wdata_i   (bus_wdata_i),
      .ctrl_o    (ctrl_w[g]),
      .mask_o    (mask_w[g]),
      .pend_o    (pend_w[g])
    );

    assign mask_flat[g*PINS +: PINS] = mask_w[g];
    assign pend_flat[g*PINS +: PINS] = pend_w[g];
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int g = 0; g < NGROUP; g++) begin
      if (sel_c[g]) bus_rdata_o |= ctrl_w[g];
      if (sel_m[g]) bus_rdata_o |= DATA_W'(mask_w[g]);
      if (sel_p[g]) bus_rdata_o |= DATA_W'(pend_w[g]);
    end
  end

  assign irq_o = |(pend_flat & ~mask_flat);

  a_r11_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_flat != '0));

  a_r12_stray_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && ({sel_c, sel_m, sel_p} == '0)) |=> $stable(mask_flat));
endmodule

// File: tb/gpint_ctrl_tb.sv
module gpint_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '1;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  gpint_ctrl u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pins_i      (pins),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  function automatic logic [11:0] a_ctrl(int g); return 12'h700 + 12'(4*g); endfunction
  function automatic logic [11:0] a_mask(int g); return 12'h900 + 12'(4*g); endfunction
  function automatic logic [11:0] a_pend(int g); return 12'hA00 + 12'(4*g); endfunction

  // monitor: one expected item per cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = q.pop_front();
      got = it.is_irq ? {31'd0, irq} : rdata;
      checks++;
      if (got !== it.exp) begin
        failures++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    addr = a;
    q.push_back('{1'b0, e, tag});
    step();
  endtask

  task automatic chk_irq(logic e, string tag);
    q.push_back('{1'b1, {31'd0, e}, tag});
    step();
  endtask

  task automatic pins_irq(int bitn, logic v, logic e, string tag);
    pins[bitn] = v;
    q.push_back('{1'b1, {31'd0, e}, tag});
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    step();

    rd(a_ctrl(0), 32'h0, "R1 ctrl reset");
    rd(a_mask(0), 32'h0000_00ff, "R1 mask reset");
    rd(a_mask(3), 32'h0000_00ff, "R1 mask3 reset");
    rd(a_pend(0), 32'h0, "R1 pend reset");
    chk_irq(1'b0, "R1 irq reset");

    // low level, group 0 pin 0
    wr(a_mask(0), 32'hfe);
    pins_irq(0, 1'b0, 1'b1, "R3 low level raises irq");
    rd(a_pend(0), 32'h01, "R3 pending set");
    wr(a_pend(0), 32'h01);
    rd(a_pend(0), 32'h01, "R3 re-asserts while low");
    pins_irq(0, 1'b1, 1'b1, "R3 pending held after release");
    wr(a_pend(0), 32'h01);
    rd(a_pend(0), 32'h0, "R9 clear sticks");
    chk_irq(1'b0, "R11 no pending no irq");

    // high level, group 1 pin 2
    wr(a_ctrl(1), 32'h0000_0100);
    rd(a_ctrl(1), 32'h0000_0100, "R2 ctrl slot readback");
    rd(a_pend(1), 32'h04, "R4 high level pending while masked");
    chk_irq(1'b0, "R11 masked pin silent");
    wr(a_mask(1), 32'hfb);
    chk_irq(1'b1, "R11 unmask raises irq");
    pins_irq(10, 1'b0, 1'b1, "R4 pending held");
    wr(a_pend(1), 32'h04);
    rd(a_pend(1), 32'h0, "R4 clear sticks once low");
    chk_irq(1'b0, "R11 irq drops");

    // reserved codes on group 1
    wr(a_ctrl(1), 32'hffff_ffff);
    rd(a_ctrl(1), 32'h7777_7777, "R2 spare slot bits read 0");
    for (int k = 8; k < 16; k++) pins[k] = 1'b0;
    step();
    for (int k = 8; k < 16; k++) pins[k] = 1'b1;
    step();
    rd(a_pend(1), 32'h0, "R8 reserved codes never pend");

    // falling edge, group 2 pin 5
    wr(a_ctrl(2), 32'h0020_0000);
    wr(a_mask(2), 32'hdf);
    pins_irq(21, 1'b0, 1'b1, "R5 falling edge");
    rd(a_pend(2), 32'h20, "R5 pending bit 5");
    wr(a_pend(2), 32'h20);
    rd(a_pend(2), 32'h0, "R5 steady low no re-assert");
    pins_irq(21, 1'b1, 1'b0, "R5 rising ignored");

    // rising edge, group 3 pin 7
    wr(a_ctrl(3), 32'h3000_0000);
    wr(a_mask(3), 32'h7f);
    pins_irq(31, 1'b0, 1'b0, "R6 falling ignored");
    pins_irq(31, 1'b1, 1'b1, "R6 rising edge");
    wr(a_pend(3), 32'h80);
    chk_irq(1'b0, "R6 cleared");

    // both edges
    wr(a_ctrl(3), 32'h4000_0000);
    pins_irq(31, 1'b0, 1'b1, "R7 falling edge");
    wr(a_pend(3), 32'h80);
    chk_irq(1'b0, "R7 steady no event");
    pins_irq(31, 1'b1, 1'b1, "R7 rising edge");
    wr(a_pend(3), 32'h80);

    // collision: edge and clear in the same clock
    pins[31] = 1'b0;
    we = 1'b1; addr = a_pend(3); wdata = 32'h80;
    step();
    we = 1'b0;
    rd(a_pend(3), 32'h80, "R10 event beats clear");
    wr(a_pend(3), 32'h7f);
    rd(a_pend(3), 32'h80, "R9 zero write keeps bit");
    wr(a_pend(3), 32'h80);
    rd(a_pend(3), 32'h0, "R9 one write clears");

    // unmapped space and upper bits
    rd(12'h710, 32'h0, "R12 past last group");
    rd(12'h800, 32'h0, "R12 gap");
    rd(12'h902, 32'h0, "R12 unaligned");
    wr(12'h910, 32'h0);
    wr(12'h800, 32'hffff_ffff);
    rd(a_mask(0), 32'hfe, "R12 stray write ignored");
    rd(a_ctrl(0), 32'h0, "R12 ctrl untouched");
    wr(a_mask(2), 32'hffff_ff00);
    rd(a_mask(2), 32'h0, "R2 mask upper bits read 0");
    chk_irq(1'b0, "R11 final idle");

    wait (q.size() == 0);
    step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule